// File: doc/BRIEF.md
# Triangular Spread Profile Generator

This block produces the frequency-offset word that steers a fractional feedback divider so that a reference-derived clock is spread downward with a triangular profile. It runs in the reference clock domain, nominally 25 MHz. Each cycle, the signed offset in parts per million moves in a straight line from 0 to the deepest point, −5000 ppm (−0.5 %), and then back to 0. One full excursion takes 794 reference cycles, which gives a modulation rate of roughly 31.5 kHz.

The spread request is a level. The block looks at it only while the offset sits at zero. A request that rises starts a full profile. A request that falls during a profile lets the current excursion finish at zero, so the divider never sees a frequency step. A one-cycle turn strobe marks both extremes of the triangle, which gives checking logic a fixed reference point.

Top module: `spread_profile_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows offset_ppm = 0 and turn_stb = 0. This holds both for reset at start-up and for reset asserted in the middle of a profile.
- R2: While the block is idle and spread_en is low, offset_ppm stays at 0 and turn_stb stays low.
- R3: During the deepening half, offset_ppm after the i-th edge of the ramp (i = 1..397) equals −floor(i·5000/397).
- R4: During the returning half, offset_ppm after the j-th edge of the ramp (j = 1..397) equals −(5000 − floor(j·5000/397)).
- R5: offset_ppm never leaves the range −5000..0. Between consecutive cycles it changes by at most 13 ppm.
- R6: One profile lasts exactly 794 cycles. While spread_en stays high, the next profile begins on the edge right after the return to 0, with no extra cycle at zero.
- R7: turn_stb is high for exactly one cycle on the cycle in which offset_ppm reaches −5000, and on the cycle in which it returns to 0 at the end of a profile. It is low in every other cycle.
- R8: If spread_en goes low in the middle of a profile, that profile still runs to completion. After the return to 0, offset_ppm then stays at 0.
- R9: If spread_en is sampled high while the block is idle, offset_ppm remains 0 for one more cycle and the deepening ramp starts on the following edge. A high level on spread_en that lasts only one cycle while idle launches exactly one full profile.
- R10: offset_ppm is a 16-bit two's-complement number in units of 1 ppm. Negative values mean a lower frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 25 MHz nominal |
| rst_n | input | 1 | Synchronous active-low reset |
| spread_en | input | 1 | Spread request level, acted on only at the zero point |
| offset_ppm | output | 16 | Signed frequency offset in ppm, range −5000..0 |
| turn_stb | output | 1 | One-cycle pulse at each extreme of the triangle |

## Verification
The hardest case to reach from the ports is a spread request that changes partway through a profile. For the block to behave correctly, the request must be ignored until the offset comes back to zero. The stimulus drops spread_en at a chosen cycle inside the deepening half of the second of two back-to-back profiles, while the offset is far from zero. The bench checks every remaining step of that profile against the closed-form ramp values, and then checks that the output stays at zero afterwards. A separate scenario applies a one-cycle request pulse while the block is idle, to show that sampling happens only at the zero point in that direction too.

// File: rtl/ssm_pkg.sv
// Shared types for the triangular spread profile generator.
// Assumes nothing beyond the 1800-2017 enum rules.
package ssm_pkg;

    // Ramp direction: deepening moves away from zero, returning moves back to it.
    typedef enum logic {
        DIR_DEEPEN = 1'b0,
        DIR_RETURN = 1'b1
    } ramp_dir_e;

endpackage

// File: rtl/ssm_sweep_seq.sv
// Sequencer for the triangle profile. It counts cycles inside each ramp,
// flips the direction at each extreme, and samples the spread request only
// at the zero point, either while idle or on the final edge of a return ramp.
// It also produces the registered turn strobe.
// Assumes HALF_LEN >= 2.
module ssm_sweep_seq
    import ssm_pkg::*;
#(
    parameter int unsigned HALF_LEN = 397
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      spread_en,
    output logic      running,
    output ramp_dir_e dir,
    output logic      ramp_last,
    output logic      turn_stb
);

    localparam int unsigned CNT_W = $clog2(HALF_LEN);

    logic [CNT_W-1:0] cnt_q;

    // Marks the final edge of the current ramp.
    always_comb ramp_last = running && (cnt_q == CNT_W'(HALF_LEN - 1));

    // Tracks the ramp position and direction, and re-samples the request at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            dir      <= DIR_DEEPEN;
            cnt_q    <= '0;
            turn_stb <= 1'b0;
        end else begin
            turn_stb <= ramp_last;
            if (!running) begin
                running <= spread_en;
                dir     <= DIR_DEEPEN;
                cnt_q   <= '0;
            end else if (ramp_last) begin
                cnt_q <= '0;
                if (dir == DIR_DEEPEN) begin
                    dir <= DIR_RETURN;
                end else begin
                    dir     <= DIR_DEEPEN;
                    running <= spread_en;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/ssm_dev_stepper.sv
// Deviation magnitude accumulator. Each active cycle it adds or subtracts the
// integer part of MAX_DEV/HALF_LEN. A remainder accumulator adds one more
// unit on some cycles, so that exactly MAX_DEV is covered in HALF_LEN steps.
// The magnitude therefore lands exactly on 0 and MAX_DEV at the turns.
// Assumes the sequencer asserts ramp_last on the final step of each ramp.
module ssm_dev_stepper
    import ssm_pkg::*;
#(
    parameter int unsigned HALF_LEN = 397,
    parameter int unsigned MAX_DEV  = 5000,
    parameter int unsigned MAG_W    = $clog2(MAX_DEV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  ramp_dir_e        dir,
    input  logic             ramp_last,
    output logic [MAG_W-1:0] mag
);

    localparam int unsigned STEP_INT = MAX_DEV / HALF_LEN;
    localparam int unsigned STEP_REM = MAX_DEV % HALF_LEN;
    localparam int unsigned ERR_W    = $clog2(2 * HALF_LEN);

    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_sum;
    logic [ERR_W-1:0] err_nxt;
    logic             carry;
    logic [MAG_W-1:0] delta;

    // Works out this cycle's step size from the remainder accumulator.
    always_comb begin
        err_sum = err_q + ERR_W'(STEP_REM);
        carry   = (err_sum >= ERR_W'(HALF_LEN));
        err_nxt = carry ? (err_sum - ERR_W'(HALF_LEN)) : err_sum;
        delta   = MAG_W'(STEP_INT) + MAG_W'(carry);
    end

    // Moves the magnitude one step in the current direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag   <= '0;
            err_q <= '0;
        end else if (step_en) begin
            mag   <= (dir == DIR_DEEPEN) ? (mag + delta) : (mag - delta);
            err_q <= ramp_last ? '0 : err_nxt;
        end
    end

endmodule

// File: rtl/spread_profile_gen.sv
// Top level of the down-spread triangle generator. It derives the ramp length
// from the reference and modulation rates, and drives a signed ppm offset that
// is the negated deviation magnitude.
// Assumes OFS_W is wide enough to hold -MAX_DEV_PPM.
module spread_profile_gen
    import ssm_pkg::*;
#(
    parameter int unsigned REF_HZ      = 25_000_000,
    parameter int unsigned MOD_HZ      = 31_500,
    parameter int unsigned MAX_DEV_PPM = 5000,
    parameter int unsigned OFS_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_en,
    output logic signed [OFS_W-1:0] offset_ppm,
    output logic                    turn_stb
);

    localparam int unsigned HALF_LEN = (REF_HZ + MOD_HZ) / (2 * MOD_HZ);
    localparam int unsigned MAG_W    = $clog2(MAX_DEV_PPM + 1);

    logic             running;
    ramp_dir_e        dir;
    logic             ramp_last;
    logic [MAG_W-1:0] mag;
    logic signed [OFS_W-1:0] mag_ext;

    ssm_sweep_seq #(
        .HALF_LEN (HALF_LEN)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spread_en (spread_en),
        .running   (running),
        .dir       (dir),
        .ramp_last (ramp_last),
        .turn_stb  (turn_stb)
    );

    ssm_dev_stepper #(
        .HALF_LEN (HALF_LEN),
        .MAX_DEV  (MAX_DEV_PPM),
        .MAG_W    (MAG_W)
    ) step_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (running),
        .dir       (dir),
        .ramp_last (ramp_last),
        .mag       (mag)
    );

    // Converts the deviation magnitude into a down-spread signed offset.
    always_comb begin
        mag_ext    = $signed(OFS_W'(mag));
        offset_ppm = -mag_ext;
    end

endmodule

// File: rtl/spread_profile_chk.sv
// Property checker for spread_profile_gen. It observes only the top-level
// ports and keeps one registered copy of the offset for its slope checks.
module spread_profile_chk #(
    parameter int unsigned OFS_W       = 16,
    parameter int unsigned MAX_DEV_PPM = 5000,
    parameter int unsigned MAX_STEP    = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [OFS_W-1:0] offset_ppm,
    input logic                    turn_stb
);

    logic signed [OFS_W-1:0] prev_ofs;
    int                      ofs_i;
    int                      prev_i;

    // Holds the previous cycle's offset for the slope and turn checks.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ofs <= '0;
        else        prev_ofs <= offset_ppm;
    end

    always_comb begin
        ofs_i  = int'(offset_ppm);
        prev_i = int'(prev_ofs);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (offset_ppm == '0 && !turn_stb));

    // R5
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_i <= 0) && (ofs_i >= -int'(MAX_DEV_PPM)));

    // R5
    slope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ofs_i - prev_i) <= int'(MAX_STEP)) && ((prev_i - ofs_i) <= int'(MAX_STEP)));

    // R7
    turn_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_stb |-> (ofs_i == 0 || ofs_i == -int'(MAX_DEV_PPM)));

    // R7
    peak_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_i == -int'(MAX_DEV_PPM) && prev_i != -int'(MAX_DEV_PPM)) |-> turn_stb);

    // R8
    zero_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_i != 0 && ofs_i == 0) |-> turn_stb);

endmodule

bind spread_profile_gen spread_profile_chk #(
    .OFS_W       (OFS_W),
    .MAX_DEV_PPM (MAX_DEV_PPM),
    .MAX_STEP    (MAX_DEV_PPM / ((REF_HZ + MOD_HZ) / (2 * MOD_HZ)) + 1)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .offset_ppm (offset_ppm),
    .turn_stb   (turn_stb)
);

// File: tb/spread_profile_gen_tb_top.sv
module spread_profile_gen_tb_top;

    localparam int HALF = 397;
    localparam int PEAK = 5000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               spread_en = 1'b0;
    logic signed [15:0] offset_ppm;
    logic               turn_stb;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spread_profile_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .spread_en  (spread_en),
        .offset_ppm (offset_ppm),
        .turn_stb   (turn_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full profile from the zero point; drops the request after edge drop_at.
    task automatic run_period(input int drop_at);
        int prev = int'(offset_ppm);
        for (int i = 1; i <= 2 * HALF; i++) begin
            int exp;
            step();
            if (i <= HALF) begin
                exp = -((i * PEAK) / HALF);
                chk("R3", int'(offset_ppm), exp);
            end else begin
                exp = -(PEAK - (((i - HALF) * PEAK) / HALF));
                chk("R4", int'(offset_ppm), exp);
            end
            chk("R7", int'(turn_stb), (i == HALF || i == 2 * HALF) ? 1 : 0);
            chk("R5", ((int'(offset_ppm) - prev) <= 13 && (prev - int'(offset_ppm)) <= 13
                       && int'(offset_ppm) <= 0 && int'(offset_ppm) >= -PEAK) ? 1 : 0, 1);
            if (i == 2 * HALF) chk("R6", int'(offset_ppm), 0);
            prev = int'(offset_ppm);
            if (i == drop_at) spread_en = 1'b0;
        end
    endtask

    task automatic check_idle(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            step();
            chk(req, int'(offset_ppm), 0);
            chk(req, int'(turn_stb), 0);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        spread_en = 1'b0;
        step(); step(); step();
        chk("R1", int'(offset_ppm), 0);
        chk("R1", int'(turn_stb), 0);
        rst_n = 1'b1;
        step();
        chk("R1", int'(offset_ppm), 0);
    endtask

    task automatic test_idle();
        check_idle("R2", 40);
    endtask

    // Back-to-back profiles, then a mid-profile drop of the request.
    task automatic test_back_to_back();
        spread_en = 1'b1;
        step();
        chk("R9", int'(offset_ppm), 0);
        chk("R10", offset_ppm[15], 0);
        run_period(0);
        run_period(300);
        check_idle("R8", 30);
    endtask

    // One-cycle request pulse while idle.
    task automatic test_pulse();
        spread_en = 1'b1;
        step();
        spread_en = 1'b0;
        chk("R9", int'(offset_ppm), 0);
        step();
        chk("R9", int'(offset_ppm), -(PEAK / HALF));
        chk("R10", int'(offset_ppm[15]), 1);
        for (int i = 2; i <= 2 * HALF; i++) step();
        chk("R9", int'(offset_ppm), 0);
        chk("R9", int'(turn_stb), 1);
        check_idle("R9", 20);
    endtask

    // Reset asserted while the offset is deep.
    task automatic test_mid_reset();
        spread_en = 1'b1;
        step();
        for (int i = 0; i < 150; i++) step();
        chk("R3", int'(offset_ppm), -((150 * PEAK) / HALF));
        rst_n = 1'b0;
        spread_en = 1'b0;
        step();
        chk("R1", int'(offset_ppm), 0);
        chk("R1", int'(turn_stb), 0);
        rst_n = 1'b1;
        check_idle("R2", 10);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog R6 actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_idle();
        test_back_to_back();
        test_pulse();
        test_mid_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule